// File: doc/BRIEF.md
# Hybrid Pulse-Width / Rate-Multiplier Tuning DAC

This block turns a 13-bit tuning value into one digital pulse train. An external low-pass filter smooths that train into the varactor tuning voltage. The value is split into two fields. The low 8 bits act as a rate multiplier and choose how many of the 256 slots in a period carry an extra clock of high time. The high 5 bits act as a pulse-width modulator and set the base high time that every slot carries. When the value is small, the period holds up to 256 narrow pulses that are spread evenly. Once the value grows past that point, the pulse count stays at 256 and each pulse gets wider. At the top of the range, neighbouring pulses join into long high intervals. Spreading the high time over many short pulses keeps the switching edges spread out and the drift low.

A tuning value is loaded as a 12-bit stored word plus a separate least significant bit, which a frequency-control loop can adjust later. After loading, the value can be nudged by single steps and stops at either end of its range. A new value reaches the output only at the start of a 8192-clock period, so no period is ever formed from two different values. While the set is not powered on (standby or off), the output is held low.

Top module: `tuning_dac`

## Requirements
- R1: After reset, `tuneCount` is 0 and `tuneOut` is low.
- R2: When `presetLoad` is high, `tuneCount` takes the value {`presetWord`, `presetLsb`} on the next clock, with `presetWord` as bits 12..1 and `presetLsb` as bit 0.
- R3: When `presetLoad` is low, a lone `stepUp` raises `tuneCount` by one and a lone `stepDown` lowers it by one. When both are high together, the count does not change. When `presetLoad` is high, it overrides both step inputs.
- R4: Stepping saturates. Stepping up from 8191 leaves 8191, and stepping down from 0 leaves 0.
- R5: With the block powered on and a steady value v, any 8192 consecutive clocks contain exactly v high clocks.
- R6: For v up to 256, the period holds v separate pulses, and each pulse is exactly one clock wide.
- R7: For 256 < v with coarse field (bits 12..8) below 31, the period holds exactly 256 pulses. Each pulse is the coarse field wide, or one clock wider. For example, v=4660 gives 256 pulses of at most 19 clocks.
- R8: When the coarse field is 31, adjacent pulses merge. At v=8191, a period has a single low clock, and so a single pulse.
- R9: A changed `tuneCount` reaches the output only at the start of the next 8192-clock period. The first period boundary falls on the first clock after reset is released.
- R10: While `powerOn` is low, `tuneOut` is low from the next clock on, and the counter still responds to load and step inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one clock is one unit pulse time |
| rstN | input | 1 | Active-low synchronous reset |
| presetWord | input | 12 | Stored tuning word; upper 12 bits of the value |
| presetLsb | input | 1 | Fine bit loaded as bit 0 of the value |
| presetLoad | input | 1 | Load strobe for the tuning value |
| stepUp | input | 1 | Increment the tuning value by one |
| stepDown | input | 1 | Decrement the tuning value by one |
| powerOn | input | 1 | High when the set is on; low forces the output low |
| tuneCount | output | 13 | Current tuning counter value |
| tuneOut | output | 1 | Pulse train for the external filter |

## Verification
The pulse train is measured over full 8192-clock windows at several values. Each window counts the high clocks, the cyclic rising edges and the longest high run. Zero and one check the lower end of the rate-multiplier field. A value of 255 confirms that every pulse stays one clock wide while the count rises. A value of 4660 shows the pulse count held at 256 while the pulses widen. The value 8191 shows pulses merging into a single low gap. A load made early in the first period, followed by a sample taken before the boundary and another taken after it, separates correct latching at the boundary from an immediate update.

// File: rtl/tdac_pkg.sv
package tdac_pkg;
  parameter int unsigned COARSE_BITS = 5;
  parameter int unsigned FINE_BITS   = 8;

  typedef struct packed {
    logic periodStart;
    logic outGate;
  } tdacStrobe_t;
endpackage

// File: rtl/tdac_ctrl.sv
module tdac_ctrl
  import tdac_pkg::*;
#(
  parameter int unsigned CW = COARSE_BITS,
  parameter int unsigned FW = FINE_BITS,
  localparam int unsigned W = CW + FW
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-2:0] presetWord,
  input  logic         presetLsb,
  input  logic         presetLoad,
  input  logic         stepUp,
  input  logic         stepDown,
  input  logic         powerOn,
  output logic [W-1:0] tuneCount,
  output logic [W-1:0] phase,
  output tdacStrobe_t  strobe
);
  localparam logic [W-1:0] MAXV = '1;

  logic onlyUp, onlyDown;
  assign onlyUp   = stepUp && !stepDown;
  assign onlyDown = stepDown && !stepUp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tuneCount <= '0;
      phase     <= '0;
    end else begin
      phase <= phase + 1'b1;
      if (presetLoad)
        tuneCount <= {presetWord, presetLsb};
      else if (onlyUp && tuneCount != MAXV)
        tuneCount <= tuneCount + 1'b1;
      else if (onlyDown && tuneCount != '0)
        tuneCount <= tuneCount - 1'b1;
    end
  end

  always_comb begin
    strobe.periodStart = (phase == '0);
    strobe.outGate     = powerOn;
  end

  // R2
  load_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    presetLoad |=> tuneCount == $past({presetWord, presetLsb}));
  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!presetLoad && onlyUp && tuneCount != MAXV) |=> tuneCount == W'($past(tuneCount) + 1'b1));
  // R3
  both_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!presetLoad && stepUp && stepDown) |=> $stable(tuneCount));
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!presetLoad && onlyUp && tuneCount == MAXV) |=> tuneCount == MAXV);
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!presetLoad && onlyDown && tuneCount == '0) |=> tuneCount == '0);
endmodule

// File: rtl/tdac_brm.sv
module tdac_brm #(
  parameter int unsigned FW = tdac_pkg::FINE_BITS
) (
  input  logic [FW-1:0] slot,
  input  logic [FW-1:0] fine,
  output logic          hit
);
  logic [FW-1:0] revSlot;

  for (genvar b = 0; b < FW; b++) begin : g_rev
    assign revSlot[b] = slot[FW-1-b];
  end

  assign hit = (revSlot < fine);
endmodule

// File: rtl/tdac_datapath.sv
module tdac_datapath
  import tdac_pkg::*;
#(
  parameter int unsigned CW = COARSE_BITS,
  parameter int unsigned FW = FINE_BITS,
  localparam int unsigned W = CW + FW
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] tuneCount,
  input  logic [W-1:0] phase,
  input  tdacStrobe_t  strobe,
  output logic         tuneOut
);
  logic [W-1:0]  activeVal, effVal;
  logic [FW-1:0] slotIdx;
  logic [CW-1:0] slotPos;
  logic [CW:0]   pulseWidth;
  logic          brmHit;

  assign effVal  = strobe.periodStart ? tuneCount : activeVal;
  assign slotIdx = phase[W-1:CW];
  assign slotPos = phase[CW-1:0];

  tdac_brm #(.FW(FW)) i_brm (
    .slot(slotIdx),
    .fine(effVal[FW-1:0]),
    .hit (brmHit)
  );

  assign pulseWidth = {1'b0, effVal[W-1:FW]} + {{CW{1'b0}}, brmHit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeVal <= '0;
      tuneOut   <= 1'b0;
    end else begin
      if (strobe.periodStart) activeVal <= tuneCount;
      tuneOut <= strobe.outGate && ({1'b0, slotPos} < pulseWidth);
    end
  end

  // R9
  boundary_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeVal != $past(activeVal)) |-> $past(phase) == '0);
  // R10
  standby_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.outGate |=> !tuneOut);
endmodule

// File: rtl/tuning_dac.sv
module tuning_dac
  import tdac_pkg::*;
#(
  parameter int unsigned CW = COARSE_BITS,
  parameter int unsigned FW = FINE_BITS,
  localparam int unsigned W = CW + FW
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-2:0] presetWord,
  input  logic         presetLsb,
  input  logic         presetLoad,
  input  logic         stepUp,
  input  logic         stepDown,
  input  logic         powerOn,
  output logic [W-1:0] tuneCount,
  output logic         tuneOut
);
  logic [W-1:0] phase;
  tdacStrobe_t  strobe;

  tdac_ctrl #(.CW(CW), .FW(FW)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .presetWord(presetWord), .presetLsb(presetLsb), .presetLoad(presetLoad),
    .stepUp(stepUp), .stepDown(stepDown), .powerOn(powerOn),
    .tuneCount(tuneCount), .phase(phase), .strobe(strobe)
  );

  tdac_datapath #(.CW(CW), .FW(FW)) i_dp (
    .clk(clk), .rstN(rstN),
    .tuneCount(tuneCount), .phase(phase), .strobe(strobe),
    .tuneOut(tuneOut)
  );
endmodule

// File: tb/test_tuning_dac.sv
module test_tuning_dac;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] presetWord = '0;
  logic        presetLsb = 1'b0;
  logic        presetLoad = 1'b0;
  logic        stepUp = 1'b0;
  logic        stepDown = 1'b0;
  logic        powerOn = 1'b1;
  logic [12:0] tuneCount;
  logic        tuneOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tuning_dac i_tuning_dac (
    .clk(clk), .rstN(rstN), .presetWord(presetWord), .presetLsb(presetLsb),
    .presetLoad(presetLoad), .stepUp(stepUp), .stepDown(stepDown),
    .powerOn(powerOn), .tuneCount(tuneCount), .tuneOut(tuneOut)
  );

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic loadVal(int v);
    presetWord = 12'(v >> 1);
    presetLsb  = v[0];
    presetLoad = 1'b1;
    @(negedge clk);
    presetLoad = 1'b0;
  endtask

  task automatic measure(output int high, output int rises, output int maxRun);
    logic first, prev;
    int run;
    high = 0; rises = 0; maxRun = 0; run = 0;
    first = 1'b0; prev = 1'b0;
    for (int i = 0; i < 8192; i++) begin
      @(negedge clk);
      if (i == 0) first = tuneOut;
      else if (tuneOut && !prev) rises++;
      if (tuneOut) begin
        high++; run++;
        if (run > maxRun) maxRun = run;
      end else run = 0;
      prev = tuneOut;
    end
    if (first && !prev) rises++;
  endtask

  task automatic t_reset;
    idle(3);
    check("R1", int'(tuneCount), 0, "count after reset");
    check("R1", int'(tuneOut), 0, "output after reset");
  endtask

  task automatic t_boundary;
    int h, r, m;
    rstN = 1'b1;
    idle(10);
    loadVal(8191);
    check("R2", int'(tuneCount), 8191, "loaded count");
    idle(4000);
    check("R9", int'(tuneOut), 0, "output before boundary");
    idle(4260);
    check("R9", int'(tuneOut), 1, "output after boundary");
    measure(h, r, m);
    check("R5", h, 8191, "high clocks v=8191");
    check("R8", r, 1, "pulses v=8191");
  endtask

  task automatic t_duty(int v, int expRises, int expMax, string req);
    int h, r, m;
    loadVal(v);
    idle(8200);
    measure(h, r, m);
    check("R5", h, v, $sformatf("high clocks v=%0d", v));
    check(req, r, expRises, $sformatf("pulses v=%0d", v));
    check(req, m, expMax, $sformatf("widest pulse v=%0d", v));
  endtask

  task automatic t_steps;
    loadVal(8190);
    stepUp = 1'b1; @(negedge clk);
    check("R3", int'(tuneCount), 8191, "step up");
    @(negedge clk); stepUp = 1'b0;
    check("R4", int'(tuneCount), 8191, "saturate high");
    loadVal(1);
    stepDown = 1'b1; @(negedge clk);
    check("R3", int'(tuneCount), 0, "step down");
    @(negedge clk);
    check("R4", int'(tuneCount), 0, "saturate low");
    stepUp = 1'b1; @(negedge clk);
    check("R3", int'(tuneCount), 0, "both steps hold");
    presetWord = 12'd100; presetLsb = 1'b1; presetLoad = 1'b1;
    @(negedge clk);
    presetLoad = 1'b0; stepUp = 1'b0; stepDown = 1'b0;
    check("R3", int'(tuneCount), 201, "load beats steps");
  endtask

  task automatic t_standby;
    int h, r, m;
    loadVal(4660);
    powerOn = 1'b0;
    idle(2);
    check("R10", int'(tuneOut), 0, "output low in standby");
    stepUp = 1'b1; @(negedge clk); stepUp = 1'b0;
    check("R10", int'(tuneCount), 4661, "counter steps in standby");
    measure(h, r, m);
    check("R10", h, 0, "high clocks in standby");
    powerOn = 1'b1;
  endtask

  initial begin
    t_reset();
    t_boundary();
    t_duty(0, 0, 0, "R5");
    t_duty(1, 1, 1, "R6");
    t_duty(255, 255, 1, "R6");
    t_duty(4660, 256, 19, "R7");
    t_steps();
    t_standby();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule